// File: doc/BRIEF.md
# Reorder Buffer with Precise Faults

This block is a circular, in-order queue that holds speculative results so that a core whose instructions finish out of order still presents precise architectural state. Dispatch reserves one slot per instruction at the tail. It stores the destination register number and the instruction address there. The index of the slot comes back to dispatch as the rename tag. Functional units later post a result value and a fault bit against that tag, in whatever order they finish.

Retirement looks only at the oldest slot. When that slot has finished without a fault, its value goes out on the architected-register write port and the slot is freed. When that slot has finished with a fault, the block produces a single-cycle flush pulse. The pulse carries the faulting address and a fixed handler address. At the same moment every younger slot is discarded and both pointers return to zero, so that rename state can fall back to the architected register file.

Top module: `rob_top`

## Requirements
- R1: An accepted allocation (alloc_valid and alloc_ready high at a clock edge) takes the slot whose index is shown on alloc_tag during that cycle. Consecutive allocations receive consecutive indices modulo DEPTH, and a freshly allocated slot is not finished.
- R2: alloc_ready is low whenever occupancy equals DEPTH. While it is low, alloc_valid changes neither occupancy nor any later retirement.
- R3: The oldest slot retires only after its result has been posted. Finished younger slots wait behind an unfinished oldest slot, and commit_valid stays low meanwhile.
- R4: A writeback (wb_valid at a clock edge) stores wb_value and wb_fault into slot wb_tag and marks it finished. Writebacks may arrive in any order.
- R5: A finished, fault-free oldest slot raises commit_valid for one cycle, starting at the edge after the writeback that completed it at the earliest. commit_reg and commit_value carry that slot's destination and value, strictly in allocation order. Several live slots may name the same destination, and each retires separately.
- R6: A finished, faulting oldest slot raises flush for exactly one cycle instead of commit_valid. During that cycle flush_pc holds the slot's address and redirect_pc holds HANDLER_PC. Every younger slot is discarded, occupancy reads 0, and the next allocation gets tag 0. alloc_ready is low in the cycle in which the faulting slot is at the head and ready to retire.
- R7: At most one slot retires per cycle. A run of finished slots retires on consecutive cycles.
- R8: An allocation and a fault-free retirement at the same edge leave occupancy unchanged.
- R9: After reset the buffer is empty, alloc_ready is high, alloc_tag is 0, and commit_valid and flush are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to reserve a slot |
| alloc_reg | input | REG_W | Destination register of the new slot |
| alloc_pc | input | PC_W | Instruction address of the new slot |
| alloc_ready | output | 1 | Slot can be reserved this cycle |
| alloc_tag | output | $clog2(DEPTH) | Index the next reserved slot receives |
| wb_valid | input | 1 | Result posting strobe |
| wb_tag | input | $clog2(DEPTH) | Slot being completed |
| wb_value | input | DATA_W | Result value |
| wb_fault | input | 1 | Result carries a fault |
| commit_valid | output | 1 | Architected register write strobe |
| commit_reg | output | REG_W | Architected register being written |
| commit_value | output | DATA_W | Value written |
| flush | output | 1 | Squash and redirect pulse |
| flush_pc | output | PC_W | Address of the faulting instruction |
| redirect_pc | output | PC_W | Handler fetch address |
| occupancy | output | $clog2(DEPTH)+1 | Number of live slots |

## Verification
The hardest situation to reach from the ports is a fault in the middle of the buffer. Older finished slots must drain normally, and the younger finished slots behind the fault must vanish without any register write. The bench builds this case by posting results in a scrambled order. The youngest slot completes first, then the faulting one, and the oldest last, so the fault reaches the head only after two clean retirements. The bench also fills the buffer and then completes the head last. This stalls a full queue of finished entries and checks that they then drain on back-to-back cycles. Rotated writeback orders at every fill level exercise pointer wrap-around.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_RETIRE = 2'd1,
    ACT_FAULT  = 2'd2
  } retire_act_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head/tail pointers with an extra wrap bit; DEPTH must be a power of two.
module rob_ptrs #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic                       clear,
  output logic [$clog2(DEPTH)-1:0]   head_idx,
  output logic [$clog2(DEPTH)-1:0]   tail_idx,
  output logic [$clog2(DEPTH):0]     occupancy,
  output logic                       full
);
  localparam int IW = $clog2(DEPTH);

  logic [IW:0] head_q, tail_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
    end
  end

  assign head_idx  = head_q[IW-1:0];
  assign tail_idx  = tail_q[IW-1:0];
  assign occupancy = tail_q - head_q;
  assign full      = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);
endmodule

// File: rtl/rob_store.sv
// Slot storage: metadata written by the allocate port, results by the
// writeback port (one write port per array), per-slot status flags.
module rob_store #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_we,
  input  logic [$clog2(DEPTH)-1:0] alloc_idx,
  input  logic [REG_W-1:0]         alloc_reg,
  input  logic [PC_W-1:0]          alloc_pc,
  input  logic                     wb_we,
  input  logic [$clog2(DEPTH)-1:0] wb_idx,
  input  logic [DATA_W-1:0]        wb_val,
  input  logic                     wb_fault,
  input  logic [$clog2(DEPTH)-1:0] head_idx,
  output logic [REG_W-1:0]         head_reg,
  output logic [PC_W-1:0]          head_pc,
  output logic [DATA_W-1:0]        head_val,
  output logic                     head_done,
  output logic                     head_fault
);
  logic [REG_W-1:0]  dst_mem [DEPTH];
  logic [PC_W-1:0]   pc_mem  [DEPTH];
  logic [DATA_W-1:0] val_mem [DEPTH];
  logic [DEPTH-1:0]  done_q, fault_q;

  always_ff @(posedge clk) begin
    if (alloc_we) begin
      dst_mem[alloc_idx] <= alloc_reg;
      pc_mem[alloc_idx]  <= alloc_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (wb_we) val_mem[wb_idx] <= wb_val;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        done_q[g]  <= 1'b0;
        fault_q[g] <= 1'b0;
      end else if (wb_we && wb_idx == g) begin
        done_q[g]  <= 1'b1;
        fault_q[g] <= wb_fault;
      end else if (alloc_we && alloc_idx == g) begin
        done_q[g]  <= 1'b0;
        fault_q[g] <= 1'b0;
      end
    end
  end

  assign head_reg   = dst_mem[head_idx];
  assign head_pc    = pc_mem[head_idx];
  assign head_val   = val_mem[head_idx];
  assign head_done  = done_q[head_idx];
  assign head_fault = fault_q[head_idx];
endmodule

// File: rtl/rob_commit.sv
// Retirement decision for the head slot plus registered retire/flush outputs.
module rob_commit
  import rob_pkg::*;
#(
  parameter int                REG_W      = 5,
  parameter int                DATA_W     = 32,
  parameter int                PC_W       = 32,
  parameter logic [PC_W-1:0]   HANDLER_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nonempty,
  input  logic              head_done,
  input  logic              head_fault,
  input  logic [REG_W-1:0]  head_reg,
  input  logic [DATA_W-1:0] head_val,
  input  logic [PC_W-1:0]   head_pc,
  output retire_act_e       act,
  output logic              commit_valid,
  output logic [REG_W-1:0]  commit_reg,
  output logic [DATA_W-1:0] commit_value,
  output logic              flush,
  output logic [PC_W-1:0]   flush_pc,
  output logic [PC_W-1:0]   redirect_pc
);
  always_comb begin
    act = ACT_HOLD;
    if (nonempty && head_done) act = head_fault ? ACT_FAULT : ACT_RETIRE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_valid <= 1'b0;
      commit_reg   <= '0;
      commit_value <= '0;
      flush        <= 1'b0;
      flush_pc     <= '0;
      redirect_pc  <= '0;
    end else begin
      commit_valid <= (act == ACT_RETIRE);
      flush        <= (act == ACT_FAULT);
      if (act == ACT_RETIRE) begin
        commit_reg   <= head_reg;
        commit_value <= head_val;
      end
      if (act == ACT_FAULT) begin
        flush_pc    <= head_pc;
        redirect_pc <= HANDLER_PC;
      end
    end
  end
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int                DEPTH      = 8,
  parameter int                REG_W      = 5,
  parameter int                DATA_W     = 32,
  parameter int                PC_W       = 32,
  parameter logic [PC_W-1:0]   HANDLER_PC = 32'h0000_0080
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_valid,
  input  logic [REG_W-1:0]         alloc_reg,
  input  logic [PC_W-1:0]          alloc_pc,
  output logic                     alloc_ready,
  output logic [$clog2(DEPTH)-1:0] alloc_tag,
  input  logic                     wb_valid,
  input  logic [$clog2(DEPTH)-1:0] wb_tag,
  input  logic [DATA_W-1:0]        wb_value,
  input  logic                     wb_fault,
  output logic                     commit_valid,
  output logic [REG_W-1:0]         commit_reg,
  output logic [DATA_W-1:0]        commit_value,
  output logic                     flush,
  output logic [PC_W-1:0]          flush_pc,
  output logic [PC_W-1:0]          redirect_pc,
  output logic [$clog2(DEPTH):0]   occupancy
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0]     head_idx;
  logic              full, push;
  logic [REG_W-1:0]  head_reg;
  logic [PC_W-1:0]   head_pc;
  logic [DATA_W-1:0] head_val;
  logic              head_done, head_fault;
  retire_act_e       act;

  assign alloc_ready = !full && (act != ACT_FAULT);
  assign push        = alloc_valid && alloc_ready;

  rob_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk(clk), .rst(rst), .push(push), .pop(act == ACT_RETIRE),
    .clear(act == ACT_FAULT), .head_idx(head_idx), .tail_idx(alloc_tag),
    .occupancy(occupancy), .full(full)
  );

  rob_store #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)) store_i (
    .clk(clk), .rst(rst),
    .alloc_we(push), .alloc_idx(alloc_tag), .alloc_reg(alloc_reg), .alloc_pc(alloc_pc),
    .wb_we(wb_valid), .wb_idx(wb_tag), .wb_val(wb_value), .wb_fault(wb_fault),
    .head_idx(head_idx), .head_reg(head_reg), .head_pc(head_pc), .head_val(head_val),
    .head_done(head_done), .head_fault(head_fault)
  );

  rob_commit #(.REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) commit_i (
    .clk(clk), .rst(rst), .nonempty(occupancy != '0),
    .head_done(head_done), .head_fault(head_fault), .head_reg(head_reg),
    .head_val(head_val), .head_pc(head_pc), .act(act),
    .commit_valid(commit_valid), .commit_reg(commit_reg), .commit_value(commit_value),
    .flush(flush), .flush_pc(flush_pc), .redirect_pc(redirect_pc)
  );
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   alloc_valid,
  input logic                   alloc_ready,
  input logic                   commit_valid,
  input logic                   flush,
  input logic [$clog2(DEPTH):0] occupancy
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) <= DEPTH);

  p_full_refuse_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(occupancy) == DEPTH) |-> !alloc_ready);

  p_refused_no_growth_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !alloc_ready) |=> (int'(occupancy) <= int'($past(occupancy))));

  p_commit_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> (int'($past(occupancy)) != 0));

  p_flush_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (rst)
    flush |-> (occupancy == '0));

  p_flush_blocks_alloc_r6: assert property (@(posedge clk) disable iff (rst)
    flush |-> !$past(alloc_ready));

  p_flush_no_commit_r6: assert property (@(posedge clk) disable iff (rst)
    !(flush && commit_valid));

  p_one_retire_r7: assert property (@(posedge clk) disable iff (rst)
    !flush |-> (int'(occupancy) + 1 >= int'($past(occupancy))));
endmodule

bind rob_top rob_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .commit_valid(commit_valid), .flush(flush), .occupancy(occupancy)
);

// File: tb/rob_top_tb_top.sv
module rob_top_tb_top;
  localparam int DEPTH = 8;
  localparam int REG_W = 5;
  localparam int DATA_W = 32;
  localparam int PC_W = 32;
  localparam int IW = $clog2(DEPTH);
  localparam logic [PC_W-1:0] HPC = 32'h0000_0080;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, alloc_valid, alloc_ready, wb_valid, wb_fault;
  logic commit_valid, flush;
  logic [REG_W-1:0] alloc_reg, commit_reg;
  logic [PC_W-1:0] alloc_pc, flush_pc, redirect_pc;
  logic [IW-1:0] alloc_tag, wb_tag;
  logic [DATA_W-1:0] wb_value, commit_value;
  logic [IW:0] occupancy;

  rob_top #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W), .HANDLER_PC(HPC)) dut_i (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_reg(alloc_reg),
    .alloc_pc(alloc_pc), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_fault(wb_fault),
    .commit_valid(commit_valid), .commit_reg(commit_reg), .commit_value(commit_value),
    .flush(flush), .flush_pc(flush_pc), .redirect_pc(redirect_pc), .occupancy(occupancy)
  );

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Retirement and flush log, sampled mid-cycle.
  logic [REG_W-1:0]  lg_reg [256];
  logic [DATA_W-1:0] lg_val [256];
  int                lg_cyc [256];
  int lg_n = 0;
  int fl_n = 0;
  logic [PC_W-1:0] fl_pc, fl_red;
  always @(negedge clk) begin
    if (commit_valid && lg_n < 256) begin
      lg_reg[lg_n] = commit_reg;
      lg_val[lg_n] = commit_value;
      lg_cyc[lg_n] = cyc;
      lg_n = lg_n + 1;
    end
    if (flush) begin
      fl_n = fl_n + 1;
      fl_pc = flush_pc;
      fl_red = redirect_pc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_alloc(input logic [REG_W-1:0] r, input logic [PC_W-1:0] pc,
                          output logic [IW-1:0] tag);
    alloc_valid = 1'b1; alloc_reg = r; alloc_pc = pc;
    tag = alloc_tag;
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic do_wb(input logic [IW-1:0] tag, input logic [DATA_W-1:0] v, input logic f);
    wb_valid = 1'b1; wb_tag = tag; wb_value = v; wb_fault = f;
    @(posedge clk); #1;
    wb_valid = 1'b0; wb_fault = 1'b0;
  endtask

  bit timed_out = 0;

  task automatic run_tests();
    logic [IW-1:0] tg [DEPTH];
    logic [IW-1:0] ta, tb;
    int base, fbase;

    // R9: reset state
    chk(alloc_ready == 1'b1, "R9", "alloc_ready", alloc_ready, 1);
    chk(occupancy == 0, "R9", "occupancy", occupancy, 0);
    chk(alloc_tag == 0, "R9", "alloc_tag", alloc_tag, 0);
    chk(!commit_valid && !flush, "R9", "commit/flush", {commit_valid, flush}, 0);

    // R1/R2: fill, tags in order, then refuse
    base = lg_n;
    for (int i = 0; i < DEPTH; i++) begin
      do_alloc(REG_W'(i % 3), PC_W'(32'h100 + 4 * i), tg[i]);
      chk(tg[i] == IW'(i), "R1", "alloc tag", tg[i], i);
    end
    chk(!alloc_ready, "R2", "alloc_ready when full", alloc_ready, 0);
    chk(occupancy == DEPTH, "R2", "occupancy full", occupancy, DEPTH);
    alloc_valid = 1'b1; alloc_reg = 5'd31; alloc_pc = 32'hDEAD;
    idle(2);
    alloc_valid = 1'b0;
    chk(occupancy == DEPTH, "R2", "occupancy after refused alloc", occupancy, DEPTH);

    // R3/R4: completions out of order, head last
    for (int i = DEPTH - 1; i >= 1; i--) do_wb(tg[i], DATA_W'(1000 + i), 1'b0);
    idle(3);
    chk(lg_n == base, "R3", "no retire before head done", lg_n - base, 0);
    do_wb(tg[0], DATA_W'(1000), 1'b0);
    idle(DEPTH + 4);
    chk(lg_n - base == DEPTH, "R5", "retire count", lg_n - base, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk(lg_reg[base + i] == REG_W'(i % 3), "R5", "retired reg", lg_reg[base + i], i % 3);
      chk(lg_val[base + i] == DATA_W'(1000 + i), "R4", "retired value", lg_val[base + i], 1000 + i);
      if (i > 0)
        chk(lg_cyc[base + i] == lg_cyc[base + i - 1] + 1, "R7", "back-to-back retire",
            lg_cyc[base + i] - lg_cyc[base + i - 1], 1);
    end
    chk(occupancy == 0, "R5", "drained", occupancy, 0);

    // R8: allocate during a retirement
    base = lg_n;
    do_alloc(5'd9, 32'h300, ta);
    do_wb(ta, 32'd55, 1'b0);
    do_alloc(5'd10, 32'h304, tb);
    chk(occupancy == 1, "R8", "occupancy with alloc+retire", occupancy, 1);
    chk(tb == IW'(ta + 1), "R1", "tag wrap/increment", tb, IW'(ta + 1));
    do_wb(tb, 32'd66, 1'b0);
    idle(4);
    chk(lg_n - base == 2 && lg_val[base] == 55 && lg_val[base + 1] == 66, "R8",
        "retired pair", lg_n - base, 2);

    // R6: fault in the middle
    base = lg_n; fbase = fl_n;
    for (int i = 0; i < 4; i++) do_alloc(REG_W'(20 + i), PC_W'(32'h200 + 4 * i), tg[i]);
    do_wb(tg[3], 32'd203, 1'b0);
    do_wb(tg[2], 32'd202, 1'b1);
    do_wb(tg[1], 32'd201, 1'b0);
    do_wb(tg[0], 32'd200, 1'b0);
    idle(8);
    chk(lg_n - base == 2, "R6", "only older slots retire", lg_n - base, 2);
    chk(lg_val[base] == 200 && lg_val[base + 1] == 201, "R6", "older values", lg_val[base + 1], 201);
    chk(fl_n - fbase == 1, "R6", "one flush pulse", fl_n - fbase, 1);
    chk(fl_pc == 32'h208, "R6", "flush_pc", fl_pc, 32'h208);
    chk(fl_red == HPC, "R6", "redirect_pc", fl_red, HPC);
    chk(occupancy == 0, "R6", "occupancy after flush", occupancy, 0);
    chk(alloc_tag == 0, "R6", "tag after flush", alloc_tag, 0);

    // Sweep: every fill level, rotated completion order, wrap-around
    for (int rnd = 0; rnd < 24; rnd++) begin
      int k = 1 + rnd % DEPTH;
      base = lg_n;
      for (int i = 0; i < k; i++) do_alloc(REG_W'(rnd + i), PC_W'(4 * i), tg[i]);
      for (int i = 0; i < k; i++) begin
        int j = (i + rnd) % k;
        do_wb(tg[j], DATA_W'(rnd * 100 + j), 1'b0);
      end
      idle(k + 4);
      chk(lg_n - base == k, "R7", "sweep retire count", lg_n - base, k);
      for (int i = 0; i < k; i++) begin
        chk(lg_val[base + i] == DATA_W'(rnd * 100 + i), "R4", "sweep value order",
            lg_val[base + i], rnd * 100 + i);
        chk(lg_reg[base + i] == REG_W'(rnd + i), "R5", "sweep reg order",
            lg_reg[base + i], REG_W'(rnd + i));
      end
    end
  endtask

  initial begin
    rst = 1'b1; alloc_valid = 1'b0; alloc_reg = '0; alloc_pc = '0;
    wb_valid = 1'b0; wb_tag = '0; wb_value = '0; wb_fault = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule